// File: doc/BRIEF.md
# Driver Fault Protection Controller

This block holds the protection logic for a bank of low-side output drivers. For each channel it receives one overcurrent comparator bit and one "channel commanded on" bit. It also receives a global overtemperature bit, an undervoltage bit and the enable/reset pin. From these it produces a per-channel shutdown mask, a global output-disable and an active-low fault flag. Analog sensing, comparator thresholds and hysteresis happen elsewhere. This block only turns those comparator bits into shutdown decisions, using a free-running system clock.

An overcurrent indication must stay present for a programmable number of consecutive clock cycles before it counts. Once it counts, it latches a shutdown for that one channel only. The latch holds until the enable/reset pin is raised or the block is power-on reset. Overtemperature shuts off every output while it lasts and is not remembered. Undervoltage acts exactly like a held enable/reset. It disables the outputs and clears every latched fault.

Top module: `drv_fault_guard`

## Requirements
- R1: After power-on reset (`rstN` low) the shutdown mask is all zero and `faultFlagN` is 1, given `overTemp`, `underVolt` and `enRst` all at 0.
- R2: An overcurrent bit held for fewer than `QUAL_CYCLES` consecutive qualifying rising edges latches nothing. Any cycle with the bit low restarts the count from zero.
- R3: An overcurrent bit held for `QUAL_CYCLES` consecutive qualifying rising edges sets the mask bit at the same index on the last of those edges. The bit is 1 meaning channel shut off, and no other mask bit changes.
- R4: A set mask bit stays set after its overcurrent bit drops. `faultFlagN` is 0 whenever any mask bit is 1.
- R5: `enRst` at 1 drives `globalOff` to 1 in the same cycle. All mask bits are 0 from the next rising edge on and stay 0 while it is held.
- R6: `overTemp` at 1 drives `globalOff` to 1 and `faultFlagN` to 0 in the same cycle and leaves the mask unchanged. When `overTemp` falls, both recover without any reset, unless a mask bit is set.
- R7: `underVolt` at 1 has the same effect as `enRst` at 1. It forces `globalOff`, clears the mask and holds it clear.
- R8: A channel qualifies only while its `chanOn` bit is 1 and `globalOff` is 0. An overcurrent bit on a channel that is off, or present while outputs are globally off, never latches.
- R9: Channels count and latch independently. Staggered faults on two channels set their mask bits on their own edges.
- R10: Counting done while outputs were globally off is discarded. After `enRst`, `underVolt` or `overTemp` falls with the overcurrent bit still high, a full `QUAL_CYCLES` edges are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low power-on reset |
| chanOn | input | CH_COUNT | Per-channel commanded-on state |
| ocTrip | input | CH_COUNT | Per-channel overcurrent comparator bit |
| overTemp | input | 1 | Overtemperature comparator bit |
| underVolt | input | 1 | Undervoltage lockout bit |
| enRst | input | 1 | Enable/reset pin, high disables and clears |
| shutMask | output | CH_COUNT | Per-channel latched shutdown, 1 = shut |
| globalOff | output | 1 | All outputs disabled |
| faultFlagN | output | 1 | Active-low fault flag |

## Verification
The bench sweeps the overcurrent pulse length from one edge up to past the qualification limit on every channel. It samples the mask exactly on the boundary. A counter that is off by one would latch one edge early or one edge late. A counter that does not restart after a gap would trip on two short pulses in a row. Faults are raised with the channel off, during overtemperature and under a held enable/reset. A design that counts through those windows would latch early once the window closes. Overtemperature is applied on top of a latched channel to catch a mask that it wrongly clears. It is also applied alone, to catch a flag that wrongly stays low after it ends.

// File: rtl/drv_fault_guard_pkg.sv
`timescale 1ns/1ps
package drv_fault_guard_pkg;
  // Strobes from control to the per-channel datapath
  typedef struct packed {
    logic clearAll;    // hold latches and counters at zero
    logic outputsOff;  // no channel may qualify a fault
  } guardStrobes_t;
endpackage

// File: rtl/drv_fault_guard_ctrl.sv
`timescale 1ns/1ps
module drv_fault_guard_ctrl
  import drv_fault_guard_pkg::*;
(
  input  logic          overTemp,
  input  logic          underVolt,
  input  logic          enRst,
  input  logic          anyLatched,
  output guardStrobes_t strobes,
  output logic          globalOff,
  output logic          faultFlagN
);
  logic resetLike;

  always_comb begin
    // undervoltage behaves as a held enable/reset
    resetLike          = enRst | underVolt;
    strobes.clearAll   = resetLike;
    strobes.outputsOff = resetLike | overTemp;
    globalOff          = strobes.outputsOff;
    faultFlagN         = ~(anyLatched | overTemp);
  end
endmodule

// File: rtl/drv_fault_guard_dp.sv
`timescale 1ns/1ps
module drv_fault_guard_dp
  import drv_fault_guard_pkg::*;
#(
  parameter int CH_COUNT    = 8,
  parameter int QUAL_CYCLES = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobes_t       strobes,
  input  logic [CH_COUNT-1:0] chanOn,
  input  logic [CH_COUNT-1:0] ocTrip,
  output logic [CH_COUNT-1:0] latched,
  output logic                anyLatched
);
  localparam int CNT_W = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(QUAL_CYCLES - 1);

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    logic [CNT_W-1:0] qualCnt;
    logic             qualify;

    always_comb
      qualify = chanOn[ch] & ocTrip[ch] & ~strobes.outputsOff & ~latched[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qualCnt     <= '0;
        latched[ch] <= 1'b0;
      end else if (strobes.clearAll) begin
        qualCnt     <= '0;
        latched[ch] <= 1'b0;
      end else if (!qualify) begin
        qualCnt     <= '0;
      end else if (qualCnt == LAST_CNT) begin
        qualCnt     <= '0;
        latched[ch] <= 1'b1;
      end else begin
        qualCnt     <= qualCnt + 1'b1;
      end
    end
  end

  always_comb anyLatched = |latched;
endmodule

// File: rtl/drv_fault_guard.sv
`timescale 1ns/1ps
module drv_fault_guard
  import drv_fault_guard_pkg::*;
#(
  parameter int CH_COUNT    = 8,
  parameter int QUAL_CYCLES = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] chanOn,
  input  logic [CH_COUNT-1:0] ocTrip,
  input  logic                overTemp,
  input  logic                underVolt,
  input  logic                enRst,
  output logic [CH_COUNT-1:0] shutMask,
  output logic                globalOff,
  output logic                faultFlagN
);
  guardStrobes_t strobes;
  logic          anyLatched;

  drv_fault_guard_ctrl u_ctrl (
    .overTemp   (overTemp),
    .underVolt  (underVolt),
    .enRst      (enRst),
    .anyLatched (anyLatched),
    .strobes    (strobes),
    .globalOff  (globalOff),
    .faultFlagN (faultFlagN)
  );

  drv_fault_guard_dp #(
    .CH_COUNT    (CH_COUNT),
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .chanOn     (chanOn),
    .ocTrip     (ocTrip),
    .latched    (shutMask),
    .anyLatched (anyLatched)
  );
endmodule

// File: rtl/drv_fault_guard_chk.sv
`timescale 1ns/1ps
module drv_fault_guard_chk #(
  parameter int CH_COUNT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [CH_COUNT-1:0] chanOn,
  input logic [CH_COUNT-1:0] ocTrip,
  input logic                overTemp,
  input logic                underVolt,
  input logic                enRst,
  input logic [CH_COUNT-1:0] shutMask,
  input logic                globalOff,
  input logic                faultFlagN
);
  always_comb begin
    if (rstN && (enRst || underVolt))
      AST_RESET_FORCES_OFF: assert (globalOff); // R5
  end

  always_comb begin
    if (rstN && overTemp)
      AST_HOT_FLAGS_AND_OFF: assert (globalOff && !faultFlagN); // R6
  end

  AST_RESET_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (enRst || underVolt) |=> (shutMask == '0)); // R5

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((~shutMask & $past(shutMask)) != '0) |-> $past(enRst || underVolt)); // R4

  AST_FLAG_ON_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (shutMask != '0) |-> !faultFlagN); // R4

  AST_RISE_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    ((shutMask & ~$past(shutMask) & ~$past(ocTrip & chanOn)) == '0)); // R8

  AST_RISE_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((shutMask & ~$past(shutMask)) != '0) |-> !$past(globalOff)); // R8
endmodule

bind drv_fault_guard drv_fault_guard_chk #(.CH_COUNT(CH_COUNT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanOn     (chanOn),
  .ocTrip     (ocTrip),
  .overTemp   (overTemp),
  .underVolt  (underVolt),
  .enRst      (enRst),
  .shutMask   (shutMask),
  .globalOff  (globalOff),
  .faultFlagN (faultFlagN)
);

// File: tb/drv_fault_guard_tb.sv
`timescale 1ns/1ps
module drv_fault_guard_tb;
  localparam int N = 4;
  localparam int Q = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] chanOn = '0;
  logic [N-1:0] ocTrip = '0;
  logic         overTemp = 1'b0;
  logic         underVolt = 1'b0;
  logic         enRst = 1'b0;
  logic [N-1:0] shutMask;
  logic         globalOff;
  logic         faultFlagN;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  drv_fault_guard #(.CH_COUNT(N), .QUAL_CYCLES(Q)) u_dut (
    .clk(clk), .rstN(rstN), .chanOn(chanOn), .ocTrip(ocTrip),
    .overTemp(overTemp), .underVolt(underVolt), .enRst(enRst),
    .shutMask(shutMask), .globalOff(globalOff), .faultFlagN(faultFlagN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseReset();
    enRst = 1'b1;
    #1 check("R5 globalOff on enRst", int'(globalOff), 1);
    step(1);
    check("R5 mask cleared", int'(shutMask), 0);
    enRst = 1'b0;
    step(1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 mask", int'(shutMask), 0);
    check("R1 flag", int'(faultFlagN), 1);
    check("R1 globalOff", int'(globalOff), 0);
    chanOn = '1;
    step(1);

    // R2/R3/R4 sweep over channel and pulse length
    for (int ch = 0; ch < N; ch++) begin
      for (int d = 1; d <= Q + 2; d++) begin
        int expMask;
        expMask = (d >= Q) ? (1 << ch) : 0;
        ocTrip[ch] = 1'b1;
        step(d);
        check(d >= Q ? "R3 latch on limit" : "R2 short pulse", int'(shutMask), expMask);
        ocTrip[ch] = 1'b0;
        step(2);
        check("R4 latch holds", int'(shutMask), expMask);
        check("R4 flag", int'(faultFlagN), expMask != 0 ? 0 : 1);
        pulseReset();
        check("R5 flag after reset", int'(faultFlagN), 1);
      end
    end

    // R2 restart after a one-cycle gap
    ocTrip[1] = 1'b1; step(Q - 1);
    ocTrip[1] = 1'b0; step(1);
    ocTrip[1] = 1'b1; step(Q - 1);
    check("R2 gap restarts count", int'(shutMask), 0);
    step(1);
    check("R3 latch after full run", int'(shutMask), 2);
    ocTrip = '0;
    pulseReset();

    // R9 staggered channels
    ocTrip[0] = 1'b1; step(2);
    ocTrip[2] = 1'b1; step(Q - 2);
    check("R9 ch0 latched alone", int'(shutMask), 1);
    step(2);
    check("R9 ch2 latched later", int'(shutMask), 5);
    ocTrip = '0;
    step(1);

    // R6 overtemperature over a latched mask
    overTemp = 1'b1;
    #1 check("R6 globalOff hot", int'(globalOff), 1);
    check("R6 flag hot", int'(faultFlagN), 0);
    step(3);
    check("R6 mask kept", int'(shutMask), 5);
    overTemp = 1'b0;
    #1 check("R6 globalOff cool", int'(globalOff), 0);
    check("R4 flag still low", int'(faultFlagN), 0);
    pulseReset();
    overTemp = 1'b1;
    #1 check("R6 flag hot alone", int'(faultFlagN), 0);
    step(2);
    overTemp = 1'b0;
    #1 check("R6 flag recovers", int'(faultFlagN), 1);
    check("R6 globalOff recovers", int'(globalOff), 0);
    step(1);

    // R8 channel off never latches
    chanOn[1] = 1'b0; ocTrip[1] = 1'b1;
    step(Q + 3);
    check("R8 off channel", int'(shutMask), 0);
    ocTrip[1] = 1'b0; chanOn = '1;
    step(1);

    // R8/R10 trip during overtemperature
    overTemp = 1'b1; ocTrip[3] = 1'b1;
    step(Q + 3);
    check("R8 no latch while hot", int'(shutMask), 0);
    overTemp = 1'b0;
    step(Q - 1);
    check("R10 recount after hot", int'(shutMask), 0);
    step(1);
    check("R10 latch after hot", int'(shutMask), 8);

    // R7 undervoltage clears and holds clear
    underVolt = 1'b1;
    #1 check("R7 globalOff", int'(globalOff), 1);
    step(1);
    check("R7 mask cleared", int'(shutMask), 0);
    step(Q + 2);
    check("R7 held clear", int'(shutMask), 0);
    underVolt = 1'b0;
    step(Q - 1);
    check("R10 recount after undervolt", int'(shutMask), 0);
    step(1);
    check("R10 latch after undervolt", int'(shutMask), 8);

    // R5/R10 enRst held with trip present
    enRst = 1'b1;
    step(Q + 2);
    check("R5 held clear", int'(shutMask), 0);
    check("R5 flag released", int'(faultFlagN), 1);
    enRst = 1'b0;
    step(Q - 1);
    check("R10 recount after enRst", int'(shutMask), 0);
    step(1);
    check("R10 latch after enRst", int'(shutMask), 8);
    ocTrip = '0;
    pulseReset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule